// File: doc/BRIEF.md
# Tick-Enabled Saturating Step Counter

This block produces an 8-bit step number that advances at a slow, fixed rate while running entirely on one fast system clock. A down-counting prescaler, loaded from the clock-frequency parameter, produces a one-cycle advance pulse once every `CLK_HZ` cycles. With the default frequency this gives one step per second. The step register is clocked by the system clock and only samples this pulse, so no divided clock is generated anywhere in the block.

Stepping is gated by an active-low run input. Once the step value reaches its top value of 255 it stays there until the next synchronous reset. A flag output shows that the top value has been reached. The block is meant to address a short, fixed-length sequence of actions, and it must stop on the last one rather than start again.

The step core is a two-state machine:
- **ST_RUN** is the counting state. Reset always enters it.
- **ST_FULL** is the saturated state.

There are two transitions:
- **run_to_full** is taken when a step is accepted while the count is 254.
- **full_hold** keeps the core in ST_FULL until reset.

Once the core is in ST_FULL, the prescaler stops.

Top module: `step_counter_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next outputs are `step` = 0 and `at_max` = 0.
- R2: When `run_n` is 1 at an advance edge, `step` keeps its value. When it is 0, `step` increases by exactly 1 (unless saturated).
- R3: Count rising edges starting with the first edge at which `rst` is low. Advance edges are edge numbers `CLK_HZ`, 2·`CLK_HZ`, 3·`CLK_HZ`, and so on.
- R4: `step` never wraps. After reaching 255 it stays at 255 through any number of further advance edges.
- R5: `at_max` is 1 exactly when `step` equals 255.
- R6: A synchronous reset in the middle of a run returns `step` to 0 and restarts the advance phase. The next advance is the `CLK_HZ`-th edge after reset is released.
- R7: `run_n` low on a non-advance edge has no effect on `step`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register in the block uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run_n | input | 1 | Active-low step enable |
| step | output | 8 | Current step value |
| at_max | output | 1 | High when `step` is at 255 |

## Verification
The hardest case to reach is saturation. It needs 255 accepted advance edges, and with the default frequency that would take minutes of simulated time. The bench therefore builds the block with `CLK_HZ` = 4, runs with `run_n` held low for more than 255·4 cycles, and then continues past that point to show that the value holds at 255.

The bench also drives `run_n` patterns aligned to the prescaler phase. One pattern is low only on non-advance edges. Another enables every second advance edge. Together these separate gating at the advance edge from gating on any other cycle.

// File: rtl/step_pkg.sv
package step_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_FULL = 1'b1
    } step_state_e;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic halt,
    output logic tick
);

    localparam int unsigned PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam logic [PW-1:0] RELOAD = PW'(CLK_HZ - 1);

    logic [PW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= RELOAD;
        end else if (!halt) begin
            if (remain == '0) begin
                remain <= RELOAD;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end

    always_comb begin
        tick = (remain == '0) && !halt;
    end

    // R3
    reload_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (remain == RELOAD));

    // R3
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> $stable(remain));

endmodule

// File: rtl/step_core.sv
module step_core
    import step_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run_n,
    output logic [CNT_W-1:0] count,
    output logic             at_max
);

    localparam logic [CNT_W-1:0] TOP     = '1;
    localparam logic [CNT_W-1:0] PRE_TOP = TOP - 1'b1;

    step_state_e state, state_nx;
    logic        take;

    always_comb begin
        take = tick && !run_n;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (take && count == PRE_TOP) begin
                    state_nx = ST_FULL;   // run_to_full
                end
            end
            ST_FULL: begin
                state_nx = ST_FULL;       // full_hold
            end
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            count <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_RUN && take) begin
                count <= count + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_RUN:  at_max = 1'b0;
            ST_FULL: at_max = 1'b1;
            default: at_max = 1'b0;
        endcase
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (count == '0 && !at_max));

    // R2
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        run_n |=> $stable(count));

    // R7
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    // R4
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count >= $past(count)));

    // R5
    flag_match_chk: assert property (@(posedge clk) disable iff (rst)
        at_max |-> (count == TOP));

endmodule

// File: rtl/step_counter_top.sv
module step_counter_top #(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_n,
    output logic [CNT_W-1:0] step,
    output logic             at_max
);

    logic tick;
    logic full;

    tick_prescaler #(
        .CLK_HZ (CLK_HZ)
    ) u_pre (
        .clk  (clk),
        .rst  (rst),
        .halt (full),
        .tick (tick)
    );

    step_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .run_n  (run_n),
        .count  (step),
        .at_max (full)
    );

    assign at_max = full;

endmodule

// File: tb/tb_step_counter_top.sv
module tb_step_counter_top;

    localparam int CLK_PERIOD = 10;
    localparam int P    = 4;
    localparam int MAXV = 255;

    logic       clk   = 1'b0;
    logic       rst   = 1'b1;
    logic       run_n = 1'b1;
    logic [7:0] step;
    logic       at_max;

    int  checks = 0;
    int  errors = 0;
    int  e      = 0;
    int  exp_cnt = 0;
    bit  done   = 0;

    step_counter_top #(.CLK_HZ(P), .CNT_W(8)) dut (
        .clk    (clk),
        .rst    (rst),
        .run_n  (run_n),
        .step   (step),
        .at_max (at_max)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag);
        checks++;
        if (step !== exp_cnt[7:0]) begin
            errors++;
            $display("FAIL %s step actual %0d expected %0d (edge %0d)", tag, step, exp_cnt, e);
        end
        checks++;
        if (at_max !== (exp_cnt == MAXV)) begin
            errors++;
            $display("FAIL R5 at_max actual %0b expected %0b (edge %0d)", at_max, exp_cnt == MAXV, e);
        end
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        e = 0;
        exp_cnt = 0;
        @(negedge clk);
        rst = 1'b0;
        check(tag);
    endtask

    task automatic cycle(input logic rn, input string tag);
        run_n = rn;
        @(posedge clk);
        e++;
        if ((e % P) == 0 && !rn && exp_cnt < MAXV) exp_cnt++;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        do_reset("R1");
        // R3: continuous run, advance every P edges
        for (int i = 0; i < 6*P; i++) cycle(1'b0, "R3");
        // R2: enable every second advance edge
        for (int i = 0; i < 10*P; i++) cycle(logic'(((e+1)/P) % 2), "R2");
        // R7: run_n low only on non-advance edges
        for (int i = 0; i < 10*P; i++) cycle(logic'(((e+1) % P) == 0), "R7");
        // R6: reset in the middle of a phase
        for (int i = 0; i < P+2; i++) cycle(1'b0, "R3");
        do_reset("R6");
        for (int i = 0; i < 3*P; i++) cycle(1'b0, "R6");
        // R4: drive into saturation and beyond
        for (int i = 0; i < 256*P + 40; i++) cycle(1'b0, "R4");
        for (int i = 0; i < 3*P; i++) cycle(1'b1, "R4");
        do_reset("R6");
        for (int i = 0; i < 2*P; i++) cycle(1'b0, "R6");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule